// File: doc/BRIEF.md
# Energy-Gated Periodic Transmit Sequencer

This block sequences the radio of a self-powered sensor node. A slow 128 Hz timebase tick drives a period counter. When the period ends, the sequencer looks at a synchronised "enough stored energy" flag. If the flag is low, it counts a skipped slot and leaves the oscillator and the transmitter unpowered until the next period. If the flag is high, it captures the parallel payload (a beat-to-beat interval in 1/128 s units) and enables the crystal oscillator. After a programmable settling time it enables the transmitter and waits out a turn-on interval. It then shifts the payload out most significant bit first, one bit per strobe, and pads the burst with the transmitter still on until the fixed burst length has passed. A one-cycle done pulse closes every burst.

All warm-up, turn-on, bit and burst durations are counted in cycles of the block clock, which runs from the oscillator while a burst is active. With the defaults and a 1 MHz clock, the timing is as follows. The period is 640 ticks (5 s). The warm-up is 20 ms. The burst is 650 cycles (650 µs) and holds a 50-cycle turn-on. Each bit takes 5 cycles, which gives 200 kbit/s.

Top module: `txs_sched_top`

## Requirements
- R1: A wake event occurs after every WAKE_TICKS-th `tick_i` pulse. The energy decision is taken on the second clock edge after the clock edge that sampled that tick.
- R2: If the synchronised energy flag is 0 at the decision edge, `osc_en_o`, `tx_en_o`, `bit_o`, `bit_stb_o` and `done_o` all stay 0 for that period. In that case `skip_cnt_o` increments by one, and it saturates at all ones.
- R3: On a passing decision, `osc_en_o` rises after the decision edge. It stays high for WARM_CYCLES cycles before `tx_en_o` rises and stays high until `tx_en_o` falls.
- R4: `tx_en_o` stays high for exactly BURST_CYCLES consecutive cycles per burst.
- R5: ON_CYCLES cycles after `tx_en_o` rises, the DATA_W payload bits go out most significant bit first. Each bit is held on `bit_o` for BIT_CYCLES cycles, and `bit_stb_o` is high only in the first cycle of each bit. `bit_o` and `bit_stb_o` are 0 in every other cycle.
- R6: The payload is captured on the decision edge. Changes on `payload_i` after that edge have no effect on the bits sent.
- R7: `done_o` is a one-cycle pulse in the cycle right after `tx_en_o` falls. All enables are 0 in that cycle.
- R8: `energy_ok_i` passes through two flip-flops, so the decision uses the input level sampled two edges before the decision edge.
- R9: A wake event that arrives while a burst or its done cycle is in progress is dropped. It is neither deferred nor counted as a skip.
- R10: While `rst` is high, all outputs are 0 and `skip_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timebase pulse (128 Hz) |
| energy_ok_i | input | 1 | Asynchronous energy-sufficient flag |
| payload_i | input | DATA_W | Parallel payload (interval in 1/128 s) |
| osc_en_o | output | 1 | Crystal oscillator enable |
| tx_en_o | output | 1 | Transmitter enable |
| bit_o | output | 1 | Serial payload bit |
| bit_stb_o | output | 1 | Strobe on the first cycle of each bit |
| done_o | output | 1 | End-of-burst pulse |
| skip_cnt_o | output | SKIP_W | Saturating count of skipped periods |

## Verification
The bench drives a payload that changes on every cycle, so any late capture shows up as a wrong bit. The energy flag is driven in four patterns:
- A long low stretch makes the skip counter saturate and shows that a skipped period leaves every enable off.
- A long high stretch has wake events arriving faster than a burst completes, which separates dropping a wake from queuing it.
- A flag that toggles every few cycles lands transitions close to the decision edge, which exposes an off-by-one in the synchroniser depth.
- A return to a high level confirms that saturation holds.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CHECK  = 3'd1,
    ST_WARMUP = 3'd2,
    ST_TX_ON  = 3'd3,
    ST_SHIFT  = 3'd4,
    ST_DONE   = 3'd5
  } sched_state_e;
endpackage

// File: rtl/txs_sync.sv
module txs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/txs_wake_timer.sv
module txs_wake_timer #(
  parameter int WAKE_TICKS = 640
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic wake_o
);
  localparam int CNT_W = $clog2(WAKE_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_TICKS - 1);

  logic [CNT_W-1:0] tick_cnt_q;
  logic             wake_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt_q <= '0;
      wake_q     <= 1'b0;
    end else begin
      wake_q <= 1'b0;
      if (tick_i) begin
        if (tick_cnt_q == LAST) begin
          tick_cnt_q <= '0;
          wake_q     <= 1'b1;
        end else begin
          tick_cnt_q <= tick_cnt_q + 1'b1;
        end
      end
    end
  end

  assign wake_o = wake_q;
endmodule

// File: rtl/txs_serializer.sv
module txs_serializer #(
  parameter int DATA_W     = 24,
  parameter int BIT_CYCLES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              go_i,
  output logic              bit_o,
  output logic              stb_o
);
  localparam int LEFT_W = $clog2(DATA_W + 1);
  localparam int SUB_W  = $clog2(BIT_CYCLES + 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(BIT_CYCLES - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [LEFT_W-1:0] left_q;
  logic [SUB_W-1:0]  sub_q;
  logic              active;

  assign active = go_i && (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      left_q  <= '0;
      sub_q   <= '0;
    end else if (load_i) begin
      shreg_q <= data_i;
      left_q  <= LEFT_W'(DATA_W);
      sub_q   <= '0;
    end else if (active) begin
      if (sub_q == SUB_LAST) begin
        sub_q   <= '0;
        shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
        left_q  <= left_q - 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign bit_o = active && shreg_q[DATA_W-1];
  assign stb_o = active && (sub_q == '0);
endmodule

// File: rtl/txs_sched_top.sv
module txs_sched_top
  import txs_pkg::*;
#(
  parameter int WAKE_TICKS   = 640,
  parameter int WARM_CYCLES  = 20000,
  parameter int ON_CYCLES    = 50,
  parameter int BIT_CYCLES   = 5,
  parameter int BURST_CYCLES = 650,
  parameter int DATA_W       = 24,
  parameter int SKIP_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              energy_ok_i,
  input  logic [DATA_W-1:0] payload_i,
  output logic              osc_en_o,
  output logic              tx_en_o,
  output logic              bit_o,
  output logic              bit_stb_o,
  output logic              done_o,
  output logic [SKIP_W-1:0] skip_cnt_o
);
  localparam int SHIFT_CYCLES = BURST_CYCLES - ON_CYCLES;
  localparam int SPAN  = (WARM_CYCLES > BURST_CYCLES) ? WARM_CYCLES : BURST_CYCLES;
  localparam int CYC_W = $clog2(SPAN + 1);
  localparam logic [CYC_W-1:0] WARM_LAST  = CYC_W'(WARM_CYCLES - 1);
  localparam logic [CYC_W-1:0] ON_LAST    = CYC_W'(ON_CYCLES - 1);
  localparam logic [CYC_W-1:0] SHIFT_LAST = CYC_W'(SHIFT_CYCLES - 1);

  sched_state_e      state_q, state_d;
  logic [CYC_W-1:0]  cyc_q;
  logic [SKIP_W-1:0] skip_q;
  logic              wake, energy_s;
  logic              osc_q, tx_q, done_q;

  txs_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .async_i(energy_ok_i), .sync_o(energy_s)
  );

  txs_wake_timer #(.WAKE_TICKS(WAKE_TICKS)) u_wake (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wake_o(wake)
  );

  txs_serializer #(.DATA_W(DATA_W), .BIT_CYCLES(BIT_CYCLES)) u_ser (
    .clk(clk), .rst(rst),
    .load_i(state_q == ST_CHECK && energy_s),
    .data_i(payload_i),
    .go_i(state_q == ST_SHIFT),
    .bit_o(bit_o), .stb_o(bit_stb_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (wake) state_d = ST_CHECK;
      ST_CHECK:  state_d = energy_s ? ST_WARMUP : ST_IDLE;
      ST_WARMUP: if (cyc_q == WARM_LAST) state_d = ST_TX_ON;
      ST_TX_ON:  if (cyc_q == ON_LAST) state_d = ST_SHIFT;
      ST_SHIFT:  if (cyc_q == SHIFT_LAST) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
      osc_q   <= 1'b0;
      tx_q    <= 1'b0;
      done_q  <= 1'b0;
      skip_q  <= '0;
    end else begin
      state_q <= state_d;
      cyc_q   <= (state_d != state_q) ? '0 : cyc_q + 1'b1;
      osc_q   <= (state_d == ST_WARMUP) || (state_d == ST_TX_ON) || (state_d == ST_SHIFT);
      tx_q    <= (state_d == ST_TX_ON) || (state_d == ST_SHIFT);
      done_q  <= (state_d == ST_DONE);
      if (state_q == ST_CHECK && !energy_s && skip_q != '1)
        skip_q <= skip_q + 1'b1;
    end
  end

  assign osc_en_o   = osc_q;
  assign tx_en_o    = tx_q;
  assign done_o     = done_q;
  assign skip_cnt_o = skip_q;
endmodule

// File: rtl/txs_sched_checker.sv
module txs_sched_checker #(
  parameter int SKIP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              osc_en_o,
  input logic              tx_en_o,
  input logic              bit_o,
  input logic              bit_stb_o,
  input logic              done_o,
  input logic [SKIP_W-1:0] skip_cnt_o
);
  // R3: the transmitter never runs without the oscillator
  a_r3_osc_covers_tx: assert property (@(posedge clk) disable iff (rst)
    tx_en_o |-> osc_en_o);
  // R3: the oscillator starts before the transmitter
  a_r3_warm_first: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_en_o) |-> !tx_en_o);
  // R5: no bit activity outside the transmit window
  a_r5_bits_in_window: assert property (@(posedge clk) disable iff (rst)
    (bit_stb_o || bit_o) |-> tx_en_o);
  // R7: done is one cycle wide and all enables are off
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!osc_en_o && !tx_en_o));
  // R7: done follows the end of transmission
  a_r7_done_after_tx: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en_o) |-> done_o);
  // R2: skip counter only steps up by one
  a_r2_skip_step: assert property (@(posedge clk) disable iff (rst)
    (skip_cnt_o != $past(skip_cnt_o)) |-> (skip_cnt_o == $past(skip_cnt_o) + 1'b1));
  // R2: a skip never happens during a burst
  a_r2_skip_quiet: assert property (@(posedge clk) disable iff (rst)
    osc_en_o |-> $stable(skip_cnt_o));
endmodule

bind txs_sched_top txs_sched_checker #(.SKIP_W(SKIP_W)) u_checker (
  .clk(clk), .rst(rst), .osc_en_o(osc_en_o), .tx_en_o(tx_en_o),
  .bit_o(bit_o), .bit_stb_o(bit_stb_o), .done_o(done_o),
  .skip_cnt_o(skip_cnt_o)
);

// File: tb/tb_txs_sched_top.sv
module tb_txs_sched_top;
  localparam int WAKE = 3, WARM = 5, ON = 3, BITC = 2, BURST = 56, DW = 24, SW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, tick = 1'b0, energy = 1'b0;
  logic [DW-1:0] payload = '0;
  logic osc, tx, bo, stb, done;
  logic [SW-1:0] skip;

  txs_sched_top #(.WAKE_TICKS(WAKE), .WARM_CYCLES(WARM), .ON_CYCLES(ON),
    .BIT_CYCLES(BITC), .BURST_CYCLES(BURST), .DATA_W(DW), .SKIP_W(SW)) dut (
    .clk(clk), .rst(rst), .tick_i(tick), .energy_ok_i(energy), .payload_i(payload),
    .osc_en_o(osc), .tx_en_o(tx), .bit_o(bo), .bit_stb_o(stb), .done_o(done),
    .skip_cnt_o(skip));

  int n_checks = 0, n_err = 0, bursts = 0, skips_seen = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural timeline model: phase 0 idle, 1 deciding, 2 burst timeline at offset k
  int m_ticks, m_wake, m_e1, m_e2, m_phase, m_k, m_skip;
  logic [DW-1:0] m_pl;

  always @(posedge clk) begin
    if (rst) begin
      m_ticks = 0; m_wake = 0; m_e1 = 0; m_e2 = 0; m_phase = 0; m_k = 0; m_skip = 0; m_pl = '0;
    end else begin
      int old_wake, old_e2;
      old_wake = m_wake; old_e2 = m_e2;
      m_e2 = m_e1; m_e1 = int'(energy);
      m_wake = 0;
      if (tick) begin
        if (m_ticks == WAKE - 1) begin m_ticks = 0; m_wake = 1; end
        else m_ticks++;
      end
      case (m_phase)
        0: if (old_wake != 0) m_phase = 1;
        1: if (old_e2 != 0) begin m_phase = 2; m_k = 0; m_pl = payload; end
           else begin m_phase = 0; if (m_skip < (1 << SW) - 1) m_skip++; skips_seen++; end
        default: begin
          if (m_k == WARM + BURST) m_phase = 0;
          else m_k++;
        end
      endcase
    end
  end

  logic prev_tx = 0;
  always @(negedge clk) begin
    if (!finished) begin
      int e_osc, e_tx, e_bit, e_stb, e_done, s;
      e_osc = 0; e_tx = 0; e_bit = 0; e_stb = 0; e_done = 0;
      if (m_phase == 2) begin
        e_osc = (m_k < WARM + BURST) ? 1 : 0;
        e_tx  = (m_k >= WARM && m_k < WARM + BURST) ? 1 : 0;
        e_done = (m_k == WARM + BURST) ? 1 : 0;
        s = m_k - WARM - ON;
        if (s >= 0 && s < DW * BITC) begin
          e_bit = int'(m_pl[DW - 1 - s / BITC]);  // R6 latched value, R5 MSB first
          e_stb = (s % BITC == 0) ? 1 : 0;
        end
      end
      if (rst) begin
        chk("R10 osc", int'(osc), 0); chk("R10 tx", int'(tx), 0);
        chk("R10 done", int'(done), 0); chk("R10 skip", int'(skip), 0);
      end else begin
        chk("R3 osc_en", int'(osc), e_osc);
        chk("R4 tx_en", int'(tx), e_tx);
        chk("R5 bit", int'(bo), e_bit);
        chk("R5 strobe", int'(stb), e_stb);
        chk("R7 done", int'(done), e_done);
        chk("R2 skip_cnt", int'(skip), m_skip);
        if (tx && !prev_tx) bursts++;
      end
      prev_tx = tx;
    end
  end

  task automatic summary;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [DW-1:0] lfsr;
    lfsr = 24'hA5C3E1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      tick = (c % 4 == 0);
      lfsr = {lfsr[DW-2:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      payload = lfsr;                         // R6: changes every cycle
      if (c < 300)       energy = 1'b0;       // R2 saturation
      else if (c < 1300) energy = 1'b1;       // R9 wakes during bursts
      else if (c < 2300) energy = ((c / 7) % 3 != 0); // R8 edges near decision
      else if (c < 3000) energy = 1'b0;
      else               energy = 1'b1;
    end
    tick = 1'b0;
    repeat (80) @(negedge clk);
    chk("R1 bursts started", int'(bursts > 5), 1);
    chk("R2 skip saturated", int'(skip), (1 << SW) - 1);
    chk("R9 wakes dropped while busy", int'(bursts + skips_seen < 4000 / (4 * WAKE)), 1);
    summary();
  end
endmodule